// File: doc/BRIEF.md
# ODT Timing Window Calculator

This block derives the start and end times of an on-die-termination window from read-timing training results. A start pulse hands it a 32-bit word carrying one 4-bit read sample delay for each of four chip selects. The block walks the chip selects in ascending order. For each one whose delay is at least the largest seen so far, it fetches the read-leveling register of every active data lane over a request/response port and keeps the largest leveling phase.

When the walk ends it packs a start field and an end field into a 32-bit register value. It pulses `done_o`, and the value and a fixed write mask are ready for a register write by the surrounding logic. The start field follows the smallest sample delay. The end field follows the largest sample delay, a fixed offset and half of the worst leveling phase, rounded up. Equal maximum delays discard the phase gathered so far. A strictly larger delay keeps it.

The leveling port has two channels, request and response, and each uses valid/ready. A request holds its valid, chip select and lane steady until ready is seen. Only one read is outstanding at a time: the block takes a response only after its request has been accepted, and it issues no new request until that response arrives. The response channel can therefore stall for any number of cycles, and the block simply waits.

Top module: `odt_window_calc`

## Requirements
- R1: The sample delay of chip select n (n = 0..3) is bits [8n+3:8n] of `sample_word_i`. All other bits of the word have no effect on any output.
- R2: With m the smallest of the four delays, a = max(m-1, 0) clamped to at most 15, and the start field = max(a-1, 0). The start field is placed in bits [15:12] of `odt_value_o`.
- R3: With M the largest delay and P the tracked phase, the end field = min(M + 4 + (P+1)/2 + 1, 31), using integer division. It is placed in bits [20:16] of `odt_value_o`.
- R4: The phase of a lane is bits [7:6] of its leveling response. P is the largest phase received since the last reset of phase tracking.
- R5: Chip selects are visited from 0 to 3, and the running maximum starts at 0. A chip select is scanned only if its delay is greater than or equal to the running maximum. If the delay is equal, phase tracking is reset before the scan. If it is greater, the maximum is updated and the phase is kept.
- R6: A scan reads lanes 0 up to L-1 in ascending order. L is `lane_cnt_i` sampled with start, with 0 treated as 1 and values above 8 treated as 8. Across the run, the reads form exactly the sequence that R5 implies.
- R7: While a request is valid and not ready, valid, chip select and lane stay unchanged. After a response is accepted, no further response is accepted until a new request has been issued.
- R8: `done_o` is high for exactly one cycle per calculation. `odt_value_o` holds the result until the next calculation and has zeros outside the two fields. `odt_mask_o` is always 0x001F_F000.
- R9: A start pulse is ignored while `busy_o` is high, and the result stays that of the calculation in progress.
- R10: After reset, `busy_o`, `done_o` and `lvl_req_valid_o` are low and `odt_value_o` is zero.
- R11: If requests are accepted at once and every response arrives the cycle after its request is accepted, `done_o` is high in the cycle after rising edge number 5 + 2·R. Edges are counted after the edge that samples start, and R is the number of lane reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a calculation when idle |
| sample_word_i | input | 32 | Packed per-chip-select sample delays |
| lane_cnt_i | input | 4 | Active lane count, 1 to 8 |
| busy_o | output | 1 | Calculation in progress |
| lvl_req_valid_o | output | 1 | Leveling read request valid |
| lvl_req_ready_i | input | 1 | Leveling read request accepted |
| lvl_req_cs_o | output | 2 | Chip select of the request |
| lvl_req_lane_o | output | 3 | Lane of the request |
| lvl_rsp_valid_i | input | 1 | Leveling response valid |
| lvl_rsp_ready_o | output | 1 | Block can take the response |
| lvl_rsp_data_i | input | 8 | Leveling register content |
| done_o | output | 1 | One-cycle completion pulse |
| odt_value_o | output | 32 | Packed window register value |
| odt_mask_o | output | 32 | Write mask for the two fields |

## Verification
Each chip select costs one evaluation cycle. Each lane read costs its request-accept and response cycles. Finishing costs one cycle, and `done_o` rises one register stage after that. In the directed runs the bench answers without stalls, so it predicts the exact negative edge at which `done_o` must be high (6 + 2·R negative edges after the one that drives start) and checks it there. In the random runs, ready and response delays vary, so the bench waits for the pulse. In every run it samples the value at that negative edge and checks, one cycle later, that the pulse has dropped and the value is held.

// File: rtl/odt_calc_pkg.sv
package odt_calc_pkg;
  localparam int unsigned CS_NUM     = 4;
  localparam int unsigned DLY_W      = 4;
  localparam int unsigned DLY_STRIDE = 8;
  localparam int unsigned PH_W       = 2;
  localparam int unsigned PH_LSB     = 6;
  localparam int unsigned LVL_W      = 8;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned START_LSB  = 12;
  localparam int unsigned START_W    = 4;
  localparam int unsigned END_LSB    = 16;
  localparam int unsigned END_W      = 5;
  localparam int unsigned END_OFS    = 5;

  typedef enum logic [1:0] {CTL_IDLE, CTL_EVAL, CTL_SCAN, CTL_FINISH} ctl_state_t;
  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_WAIT} rd_state_t;
endpackage

// File: rtl/odt_lane_reader.sv
module odt_lane_reader
  import odt_calc_pkg::*;
#(
  parameter int unsigned LANES_MAX = 8,
  parameter int unsigned LANE_W    = (LANES_MAX > 1) ? $clog2(LANES_MAX) : 1,
  parameter int unsigned CNT_W     = $clog2(LANES_MAX + 1),
  parameter int unsigned CS_W      = $clog2(CS_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic [CNT_W-1:0]  lane_cnt_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [CS_W-1:0]   req_cs_o,
  output logic [LANE_W-1:0] req_lane_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [LVL_W-1:0]  rsp_data_i,
  output logic              ph_stb_o,
  output logic [PH_W-1:0]   ph_o,
  output logic              scan_done_o
);
  rd_state_t         st;
  logic [LANE_W-1:0] lane_q;
  logic [CS_W-1:0]   cs_q;
  logic              last_lane;

  assign last_lane   = (CNT_W'(lane_q) + CNT_W'(1)) == lane_cnt_i;
  assign req_valid_o = (st == RD_REQ);
  assign rsp_ready_o = (st == RD_WAIT);
  assign req_cs_o    = cs_q;
  assign req_lane_o  = lane_q;
  assign ph_stb_o    = rsp_ready_o && rsp_valid_i;
  assign ph_o        = rsp_data_i[PH_LSB +: PH_W];
  assign scan_done_o = ph_stb_o && last_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RD_IDLE;
      lane_q <= '0;
      cs_q   <= '0;
    end else begin
      case (st)
        RD_IDLE: if (kick_i) begin
          cs_q   <= cs_i;
          lane_q <= '0;
          st     <= RD_REQ;
        end
        RD_REQ: if (req_ready_i) st <= RD_WAIT;
        RD_WAIT: if (rsp_valid_i) begin
          if (last_lane) st <= RD_IDLE;
          else begin
            lane_q <= lane_q + LANE_W'(1);
            st     <= RD_REQ;
          end
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_lane_o) && $stable(req_cs_o));

  assert_single_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_i && rsp_ready_o |=> !rsp_ready_o);

  assert_lane_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> CNT_W'(req_lane_o) < lane_cnt_i);
endmodule

// File: rtl/odt_delay_track.sv
module odt_delay_track
  import odt_calc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             eval_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             ph_stb_i,
  input  logic [PH_W-1:0]  ph_i,
  output logic             scan_o,
  output logic [DLY_W-1:0] min_o,
  output logic [DLY_W-1:0] max_o,
  output logic [PH_W-1:0]  ph_o,
  output logic             have_o
);
  logic [DLY_W-1:0] min_q, max_q;
  logic [PH_W-1:0]  ph_q;
  logic             have_q;

  assign scan_o = (dly_i >= max_q);
  assign min_o  = min_q;
  assign max_o  = max_q;
  assign ph_o   = ph_q;
  assign have_o = have_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q  <= '1;
      max_q  <= '0;
      ph_q   <= '0;
      have_q <= 1'b0;
    end else if (clear_i) begin
      min_q  <= '1;
      max_q  <= '0;
      ph_q   <= '0;
      have_q <= 1'b0;
    end else begin
      if (eval_i) begin
        if (dly_i < min_q) min_q <= dly_i;
        if (dly_i == max_q) have_q <= 1'b0;
        else if (dly_i > max_q) max_q <= dly_i;
      end
      if (ph_stb_i && (!have_q || ph_i > ph_q)) begin
        ph_q   <= ph_i;
        have_q <= 1'b1;
      end
    end
  end

  assert_track_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && !clear_i |=> (max_o >= $past(dly_i)) && (min_o <= $past(dly_i)));
endmodule

// File: rtl/odt_field_calc.sv
module odt_field_calc
  import odt_calc_pkg::*;
(
  input  logic [DLY_W-1:0] min_i,
  input  logic [DLY_W-1:0] max_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic             have_i,
  output logic [REG_W-1:0] value_o
);
  localparam int unsigned SUM_W = END_W + 1;
  logic [DLY_W:0]   open_a;
  logic [DLY_W:0]   open_b;
  logic [PH_W:0]    half;
  logic [SUM_W-1:0] close_sum;
  logic [END_W-1:0] close_f;

  always_comb begin
    open_a = (min_i == '0) ? '0 : ({1'b0, min_i} - (DLY_W+1)'(1));
    if (open_a > (DLY_W+1)'(2**START_W - 1)) open_a = (DLY_W+1)'(2**START_W - 1);
    open_b = (open_a == '0) ? '0 : (open_a - (DLY_W+1)'(1));
    half = have_i ? (({1'b0, ph_i} + (PH_W+1)'(1)) >> 1) : '0;
    close_sum = SUM_W'(max_i) + SUM_W'(END_OFS) + SUM_W'(half);
    close_f = (close_sum > SUM_W'(2**END_W - 1)) ? END_W'(2**END_W - 1) : close_sum[END_W-1:0];
    value_o = '0;
    value_o[START_LSB +: START_W] = open_b[START_W-1:0];
    value_o[END_LSB +: END_W]     = close_f;
  end
endmodule

// File: rtl/odt_window_calc.sv
module odt_window_calc
  import odt_calc_pkg::*;
#(
  parameter int unsigned LANES_MAX = 8,
  parameter int unsigned LANE_W    = (LANES_MAX > 1) ? $clog2(LANES_MAX) : 1,
  parameter int unsigned CNT_W     = $clog2(LANES_MAX + 1),
  parameter int unsigned CS_W      = $clog2(CS_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [REG_W-1:0]  sample_word_i,
  input  logic [CNT_W-1:0]  lane_cnt_i,
  output logic              busy_o,
  output logic              lvl_req_valid_o,
  input  logic              lvl_req_ready_i,
  output logic [CS_W-1:0]   lvl_req_cs_o,
  output logic [LANE_W-1:0] lvl_req_lane_o,
  input  logic              lvl_rsp_valid_i,
  output logic              lvl_rsp_ready_o,
  input  logic [LVL_W-1:0]  lvl_rsp_data_i,
  output logic              done_o,
  output logic [REG_W-1:0]  odt_value_o,
  output logic [REG_W-1:0]  odt_mask_o
);
  localparam logic [REG_W-1:0] FIELD_MASK =
    (REG_W'((2**END_W) - 1) << END_LSB) | (REG_W'((2**START_W) - 1) << START_LSB);

  ctl_state_t       st;
  logic [CS_W-1:0]  cs_q;
  logic [REG_W-1:0] word_q;
  logic [CNT_W-1:0] lanes_q, lanes_eff;
  logic             done_q;
  logic [REG_W-1:0] value_q, calc_value;
  logic [DLY_W-1:0] dly_arr [CS_NUM];
  logic [DLY_W-1:0] cur_dly, t_min, t_max;
  logic [PH_W-1:0]  t_ph, rd_ph;
  logic             t_have, scan_need, rd_stb, rd_done, last_cs;
  logic             trk_clear, trk_eval, kick;

  for (genvar g = 0; g < CS_NUM; g++) begin : g_field
    assign dly_arr[g] = word_q[g*DLY_STRIDE +: DLY_W];
  end

  assign cur_dly   = dly_arr[cs_q];
  assign last_cs   = (cs_q == CS_W'(CS_NUM - 1));
  assign lanes_eff = (lane_cnt_i == '0) ? CNT_W'(1) :
                     (lane_cnt_i > CNT_W'(LANES_MAX)) ? CNT_W'(LANES_MAX) : lane_cnt_i;
  assign trk_clear = (st == CTL_IDLE) && start_i;
  assign trk_eval  = (st == CTL_EVAL);
  assign kick      = trk_eval && scan_need;
  assign busy_o    = (st != CTL_IDLE);
  assign done_o    = done_q;
  assign odt_value_o = value_q;
  assign odt_mask_o  = FIELD_MASK;

  odt_delay_track u_track (
    .clk(clk), .rst_n(rst_n), .clear_i(trk_clear), .eval_i(trk_eval), .dly_i(cur_dly),
    .ph_stb_i(rd_stb), .ph_i(rd_ph), .scan_o(scan_need), .min_o(t_min), .max_o(t_max),
    .ph_o(t_ph), .have_o(t_have)
  );

  odt_lane_reader #(.LANES_MAX(LANES_MAX), .LANE_W(LANE_W), .CNT_W(CNT_W), .CS_W(CS_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .cs_i(cs_q), .lane_cnt_i(lanes_q),
    .req_valid_o(lvl_req_valid_o), .req_ready_i(lvl_req_ready_i), .req_cs_o(lvl_req_cs_o),
    .req_lane_o(lvl_req_lane_o), .rsp_valid_i(lvl_rsp_valid_i), .rsp_ready_o(lvl_rsp_ready_o),
    .rsp_data_i(lvl_rsp_data_i), .ph_stb_o(rd_stb), .ph_o(rd_ph), .scan_done_o(rd_done)
  );

  odt_field_calc u_calc (
    .min_i(t_min), .max_i(t_max), .ph_i(t_ph), .have_i(t_have), .value_o(calc_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CTL_IDLE;
      cs_q    <= '0;
      word_q  <= '0;
      lanes_q <= CNT_W'(1);
      done_q  <= 1'b0;
      value_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        CTL_IDLE: if (start_i) begin
          word_q  <= sample_word_i;
          lanes_q <= lanes_eff;
          cs_q    <= '0;
          st      <= CTL_EVAL;
        end
        CTL_EVAL: begin
          if (scan_need) st <= CTL_SCAN;
          else if (last_cs) st <= CTL_FINISH;
          else cs_q <= cs_q + CS_W'(1);
        end
        CTL_SCAN: if (rd_done) begin
          if (last_cs) st <= CTL_FINISH;
          else begin
            cs_q <= cs_q + CS_W'(1);
            st   <= CTL_EVAL;
          end
        end
        CTL_FINISH: begin
          value_q <= calc_value;
          done_q  <= 1'b1;
          st      <= CTL_IDLE;
        end
        default: st <= CTL_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_start_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> odt_value_o[START_LSB +: START_W] <= START_W'(13));

  assert_end_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> odt_value_o[END_LSB +: END_W] >= END_W'(END_OFS));

  assert_value_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done_q) && !done_o |-> $stable(odt_value_o));
endmodule

// File: tb/sim_odt_window_calc.sv
module sim_odt_window_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] word = '0;
  logic [3:0]  lanes = 4'd1;
  logic        busy, req_valid, req_ready, rsp_valid, rsp_ready, done;
  logic [1:0]  req_cs;
  logic [2:0]  req_lane;
  logic [7:0]  rsp_data;
  logic [31:0] value, mask;

  int total = 0;
  int bad = 0;
  bit fast = 1'b1;
  logic [7:0] lreg [4][8];
  logic [4:0] exp_seq [32];
  int exp_len, seq_idx, exp_reads;
  bit seq_err;
  logic [31:0] exp_val;
  bit pend = 1'b0;
  int pdly;
  logic [7:0] pdata;

  always #5 clk = ~clk;

  odt_window_calc u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sample_word_i(word), .lane_cnt_i(lanes),
    .busy_o(busy), .lvl_req_valid_o(req_valid), .lvl_req_ready_i(req_ready),
    .lvl_req_cs_o(req_cs), .lvl_req_lane_o(req_lane), .lvl_rsp_valid_i(rsp_valid),
    .lvl_rsp_ready_o(rsp_ready), .lvl_rsp_data_i(rsp_data), .done_o(done),
    .odt_value_o(value), .odt_mask_o(mask)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  task automatic compute_exp(input logic [31:0] w, input logic [3:0] ln);
    int lc, mn, mx, ph, a, s, e;
    bit have;
    lc = (ln == 0) ? 1 : (ln > 8) ? 8 : int'(ln);
    mn = 15; mx = 0; ph = 0; have = 0; exp_len = 0;
    for (int c = 0; c < 4; c++) begin
      int d;
      d = int'(w[8*c +: 4]);
      if (d < mn) mn = d;
      if (d >= mx) begin
        if (d == mx) have = 0; else mx = d;
        for (int l = 0; l < lc; l++) begin
          int p;
          p = int'(lreg[c][l][7:6]);
          if (!have || p > ph) begin ph = p; have = 1; end
          exp_seq[exp_len] = {2'(c), 3'(l)};
          exp_len++;
        end
      end
    end
    a = (mn == 0) ? 0 : mn - 1;
    if (a > 15) a = 15;
    s = (a == 0) ? 0 : a - 1;
    e = mx + 4 + (have ? (ph + 1) / 2 : 0) + 1;
    if (e > 31) e = 31;
    exp_val = (32'(e) << 16) | (32'(s) << 12);
    exp_reads = exp_len;
  endtask

  initial begin
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      req_ready = fast ? 1'b1 : 1'($urandom % 2);
      if (pend && pdly == 0) begin
        rsp_valid = 1'b1; rsp_data = pdata;
      end else begin
        rsp_valid = 1'b0; rsp_data = 8'($urandom);
        if (pend) pdly--;
      end
      #1;
      if (rsp_valid && rsp_ready) pend = 1'b0;
      if (req_valid && req_ready) begin
        if (seq_idx >= exp_len || exp_seq[seq_idx] != {req_cs, req_lane}) seq_err = 1'b1;
        seq_idx++;
        pend  = 1'b1;
        pdly  = fast ? 0 : int'($urandom % 4);
        pdata = lreg[req_cs][req_lane];
      end
    end
  end

  task automatic run(input string tag, input logic [31:0] w, input logic [3:0] ln, input bit inject);
    int n;
    logic [31:0] held;
    compute_exp(w, ln);
    seq_idx = 0; seq_err = 1'b0;
    @(negedge clk);
    word = w; lanes = ln; start = 1'b1; n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (inject && n == 3) begin
        chk(busy == 1'b1, {tag, " R9 busy at injected start"}, 32'(busy), 32'd1);
        start = 1'b1; word = w ^ 32'h0F0F_0F0F; lanes = 4'd1;
      end else start = 1'b0;
      if (done || n > 3000) break;
    end
    chk(done == 1'b1, {tag, " R8 done seen"}, 32'(done), 32'd1);
    chk(value[15:12] == exp_val[15:12], {tag, " R2 start field"}, 32'(value[15:12]), 32'(exp_val[15:12]));
    chk(value[20:16] == exp_val[20:16], {tag, " R3 end field"}, 32'(value[20:16]), 32'(exp_val[20:16]));
    chk((value & ~32'h001F_F000) == 0, {tag, " R8 zero outside fields"}, value, exp_val);
    if (inject) chk(value == exp_val, {tag, " R9 result of first start"}, value, exp_val);
    if (fast) chk(n == 6 + 2 * exp_reads, {tag, " R11 latency"}, 32'(n), 32'(6 + 2 * exp_reads));
    held = value;
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 single pulse"}, 32'(done), 32'd0);
    chk(seq_err == 1'b0 && seq_idx == exp_len, {tag, " R6 read sequence"}, 32'(seq_idx), 32'(exp_len));
    repeat (2) @(negedge clk);
    chk(value == held, {tag, " R8 value held"}, value, held);
    chk(busy == 1'b0, {tag, " R9 idle after run"}, 32'(busy), 32'd0);
  endtask

  task automatic fill_regs(input logic [7:0] base, input bit rnd);
    for (int c = 0; c < 4; c++)
      for (int l = 0; l < 8; l++)
        lreg[c][l] = rnd ? 8'($urandom) : base;
  endtask

  initial begin
    void'($urandom(32'd2024));
    fill_regs(8'h00, 1'b0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy after reset", 32'(busy), 32'd0);
    chk(done == 1'b0, "R10 done after reset", 32'(done), 32'd0);
    chk(req_valid == 1'b0, "R10 request after reset", 32'(req_valid), 32'd0);
    chk(value == 32'd0, "R10 value after reset", value, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mask == 32'h001F_F000, "R8 write mask", mask, 32'h001F_F000);

    fast = 1'b1;
    fill_regs(8'h00, 1'b1);
    run("R5 all ties", 32'h0000_0000, 4'd8, 1'b0);
    fill_regs(8'h00, 1'b0);
    for (int l = 0; l < 8; l++) lreg[0][l] = 8'hC0;
    run("R5 tie resets phase", 32'hA0B1_0505, 4'd2, 1'b0);
    chk(value[20:16] == 5'd10, "R5 tie literal end", 32'(value[20:16]), 32'd10);
    run("R5 rise keeps phase", 32'h0000_0503, 4'd2, 1'b0);
    chk(value[20:16] == 5'd12, "R4 kept phase literal end", 32'(value[20:16]), 32'd12);
    fill_regs(8'h00, 1'b1);
    run("R5 descending", 32'h0204_090F, 4'd3, 1'b0);
    fill_regs(8'hFF, 1'b0);
    run("R6 lanes zero", 32'h0F0F_0F0F, 4'd0, 1'b0);
    chk(value == 32'h0016_D000, "R2 R3 top clamp literal", value, 32'h0016_D000);
    fill_regs(8'h00, 1'b1);
    run("R6 lanes above max", 32'h0301_0607, 4'd12, 1'b0);
    run("R1 noise bits", 32'hF2F5_F1F8, 4'd4, 1'b0);

    fast = 1'b0;
    for (int k = 0; k < 40; k++) begin
      fill_regs(8'h00, 1'b1);
      run("R1 R4 random", $urandom, 4'($urandom % 10), (k % 3) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule